// File: doc/BRIEF.md
# Local Bus Cycle Sequencer

This block is the bus-master side of a 32-bit local bus that does not pipeline addresses. A core hands it one transfer at a time: a read or a write, to memory or I/O space, of data or control type, with a word address, byte enables and write data. The sequencer turns that request into a bus cycle and drives the address, the active-low byte enables, the cycle-definition lines and an active-low address strobe. For a write it drives the data bus. It watches an active-low ready input from the responder to decide when the cycle is over, and returns a one-tick completion pulse to the core. For reads it also returns the captured data.

The block runs on a double-frequency clock `clk2`, and every bus state lasts exactly two ticks of it: phase 1, then phase 2. A cycle starts with an address state (T1) and continues with one or more data states (T2). When nothing is pending, the bus sits in an idle state (Ti). Ready is looked at only on the edge that ends a data state. If it is high there, the data state repeats as a wait state. If it is low, the cycle ends, and a request waiting at that same edge starts its address state on the next tick with no idle state between. The core holds `req_valid` and its request fields steady until it sees `req_accept` high at a rising edge. The data bus is split into an output, an output enable and an input, so that a tristate pad can be placed outside the block.

Top module: `lbus_seq`

## Requirements
- R1: While `rst` is high and on the first tick after it falls, `bus_ads_n` is 1, `bus_be_n` is all ones, `bus_d_oe` is 0, `req_done` is 0, `req_accept` is 0 (with `req_valid` low) and `rd_data` is 0.
- R2: A cycle's T1 occupies exactly two consecutive ticks with `bus_ads_n` low. `bus_ads_n` is high in every T2 and Ti tick.
- R3: The request fields are captured at the accepting edge and appear from the first T1 tick. `bus_addr` equals `req_addr`, bit i of `bus_be_n` is the inverse of bit i of `req_be`, `bus_wr` is 1 for a write, `bus_mio` equals `req_mem` and `bus_dc` equals `req_data`. These outputs do not change until the next request is accepted, whatever the request inputs do in the meantime.
- R4: `bus_rdy_n` is sampled only at the edge that ends the second tick of a T2. Its value on any other tick has no effect.
- R5: If ready is high at that sample, another two-tick T2 follows. A cycle with W wait states therefore ends at the edge 4+2W ticks after its first T1 tick began, and `req_done` stays low until then.
- R6: In Ti with no request, `bus_ads_n` stays high. A request raised in Ti is accepted at the edge ending the second Ti tick, and T1 starts on the next tick.
- R7: A request present at the edge where ready is sampled low is accepted at that edge, and its T1 starts on the very next tick, after a write as well as after a read.
- R8: `req_accept` is high only while `req_valid` is high, either in the second tick of Ti or in the sampling tick of a T2 with `bus_rdy_n` low. It is never high during T1 or in a T2 that becomes a wait state.
- R9: For a write, `bus_d_oe` rises on the second tick of T1 with `bus_d_out` equal to the write data. It stays high and stable through every T2 and is low again on the tick after the cycle ends. It is never high for a read.
- R10: Every completed cycle gives a `req_done` pulse exactly one tick wide, on the tick after the ending edge. For a read, `rd_data` then holds the `bus_d_in` value seen at that edge. A write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-frequency clock; two ticks per bus state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core has a transfer pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_data | input | 1 | 1 = data transfer, 0 = control transfer |
| req_addr | input | ADDR_W (30) | Word address (byte address bits 31..2) |
| req_be | input | DATA_W/8 (4) | Active-high byte-lane enables |
| req_wdata | input | DATA_W (32) | Write data |
| req_accept | output | 1 | Request taken at this rising edge |
| req_done | output | 1 | One-tick completion pulse |
| rd_data | output | DATA_W (32) | Data returned by the last read |
| bus_addr | output | ADDR_W (30) | Bus word address |
| bus_be_n | output | DATA_W/8 (4) | Active-low byte enables |
| bus_ads_n | output | 1 | Active-low address strobe, low during T1 |
| bus_mio | output | 1 | Memory/IO cycle definition |
| bus_dc | output | 1 | Data/control cycle definition |
| bus_wr | output | 1 | Write/read cycle definition |
| bus_rdy_n | input | 1 | Active-low ready from responder |
| bus_d_in | input | DATA_W (32) | Data bus input |
| bus_d_out | output | DATA_W (32) | Data bus output value |
| bus_d_oe | output | 1 | Data bus output enable |

## Verification
The hardest case to reach is the edge where one cycle ends and the next begins at the same moment. Ready must be low on exactly the right tick, a new request must already be waiting, and the write-data enable has to drop and the strobe fall on the same edge. The stimulus loads the next request while the current cycle is still in its address state and holds it there through random wait-state counts, so that ending-and-restarting happens many times with mixed read/write order. Ready is also driven low at random on the ticks where it must be ignored, so a sequencer that samples at the wrong phase ends a cycle early and is caught.

// File: rtl/lbus_pkg.sv
package lbus_pkg;

    // Bus state of the sequencer; each state spans two clk2 ticks.
    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_ADDR = 2'd1,
        BS_DATA = 2'd2
    } bstate_e;

    // Cycle definition carried with each transfer.
    typedef struct packed {
        logic wr;   // 1 = write
        logic mio;  // 1 = memory space
        logic dc;   // 1 = data transfer
    } cdef_t;

endpackage

// File: rtl/lbus_fsm.sv
module lbus_fsm
    import lbus_pkg::*;
(
    input  logic clk2,
    input  logic rst,
    input  logic req_valid,
    input  logic rdy_n,
    output logic take,      // request captured at this edge
    output logic finish,    // cycle ends at this edge
    output logic addr_mid,  // first tick of the address state
    output logic ads_n_o
);

    typedef struct packed {
        bstate_e st;
        logic    ph;     // 0 = phase 1, 1 = phase 2
        logic    ads_n;
    } fsm_s;

    fsm_s fsm_q, fsm_d;

    always_comb begin
        // ready only counts on the edge that closes a data state
        finish   = fsm_q.ph && (fsm_q.st == BS_DATA) && !rdy_n;
        take     = fsm_q.ph && req_valid && ((fsm_q.st == BS_IDLE) || finish);
        addr_mid = !fsm_q.ph && (fsm_q.st == BS_ADDR);

        fsm_d    = fsm_q;
        fsm_d.ph = !fsm_q.ph;
        if (fsm_q.ph) begin
            case (fsm_q.st)
                BS_IDLE: fsm_d.st = take ? BS_ADDR : BS_IDLE;
                BS_ADDR: fsm_d.st = BS_DATA;
                BS_DATA: begin
                    if (finish) fsm_d.st = take ? BS_ADDR : BS_IDLE;
                    else        fsm_d.st = BS_DATA;   // wait state
                end
                default: fsm_d.st = BS_IDLE;
            endcase
        end
        fsm_d.ads_n = (fsm_d.st != BS_ADDR);
    end

    always_ff @(posedge clk2) begin
        if (rst) begin
            fsm_q.st    <= BS_IDLE;
            fsm_q.ph    <= 1'b0;
            fsm_q.ads_n <= 1'b1;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign ads_n_o = fsm_q.ads_n;

endmodule

// File: rtl/lbus_req_hold.sv
module lbus_req_hold
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk2,
    input  logic              rst,
    input  logic              take,
    input  logic              addr_mid,
    input  logic              finish,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] addr_o,
    output logic [BE_W-1:0]   be_n_o,
    output cdef_t             cdef_o,
    output logic [DATA_W-1:0] d_out_o,
    output logic              d_oe_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be_n;
        cdef_t             cdef;
        logic [DATA_W-1:0] wdata;
        logic              oe;
    } hold_s;

    hold_s hold_q, hold_d;
    logic [BE_W-1:0] be_n_in;

    // one inverter per byte lane
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign be_n_in[g] = ~req_be[g];
    end

    always_comb begin
        hold_d = hold_q;
        if (take) begin
            hold_d.addr     = req_addr;
            hold_d.be_n     = be_n_in;
            hold_d.cdef.wr  = req_write;
            hold_d.cdef.mio = req_mem;
            hold_d.cdef.dc  = req_data;
            hold_d.wdata    = req_wdata;
            hold_d.oe       = 1'b0;          // phase 1 of T1: bus not driven
        end else if (addr_mid) begin
            hold_d.oe       = hold_q.cdef.wr; // drive from phase 2 of T1
        end else if (finish) begin
            hold_d.oe       = 1'b0;
        end
    end

    always_ff @(posedge clk2) begin
        if (rst) begin
            hold_q      <= '0;
            hold_q.be_n <= '1;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign addr_o  = hold_q.addr;
    assign be_n_o  = hold_q.be_n;
    assign cdef_o  = hold_q.cdef;
    assign d_out_o = hold_q.wdata;
    assign d_oe_o  = hold_q.oe;

endmodule

// File: rtl/lbus_rdcap.sv
module lbus_rdcap #(
    parameter int DATA_W = 32
) (
    input  logic              clk2,
    input  logic              rst,
    input  logic              finish,
    input  logic              is_write,
    input  logic [DATA_W-1:0] d_in,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              done_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rd;
        logic              done;
    } cap_s;

    cap_s cap_q, cap_d;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = finish;
        if (finish && !is_write) begin
            cap_d.rd = d_in;   // same edge that sees ready low
        end
    end

    always_ff @(posedge clk2) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign rd_data_o = cap_q.rd;
    assign done_o    = cap_q.done;

endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
    import lbus_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input  logic              clk2,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_data,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_accept,
    output logic              req_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be_n,
    output logic              bus_ads_n,
    output logic              bus_mio,
    output logic              bus_dc,
    output logic              bus_wr,
    input  logic              bus_rdy_n,
    input  logic [DATA_W-1:0] bus_d_in,
    output logic [DATA_W-1:0] bus_d_out,
    output logic              bus_d_oe
);

    logic  take, finish, addr_mid;
    cdef_t cdef;

    lbus_fsm u_fsm (
        .clk2      (clk2),
        .rst       (rst),
        .req_valid (req_valid),
        .rdy_n     (bus_rdy_n),
        .take      (take),
        .finish    (finish),
        .addr_mid  (addr_mid),
        .ads_n_o   (bus_ads_n)
    );

    lbus_req_hold #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_hold (
        .clk2      (clk2),
        .rst       (rst),
        .take      (take),
        .addr_mid  (addr_mid),
        .finish    (finish),
        .req_write (req_write),
        .req_mem   (req_mem),
        .req_data  (req_data),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_wdata (req_wdata),
        .addr_o    (bus_addr),
        .be_n_o    (bus_be_n),
        .cdef_o    (cdef),
        .d_out_o   (bus_d_out),
        .d_oe_o    (bus_d_oe)
    );

    lbus_rdcap #(
        .DATA_W (DATA_W)
    ) u_rdcap (
        .clk2      (clk2),
        .rst       (rst),
        .finish    (finish),
        .is_write  (cdef.wr),
        .d_in      (bus_d_in),
        .rd_data_o (rd_data),
        .done_o    (req_done)
    );

    assign req_accept = take;
    assign bus_mio    = cdef.mio;
    assign bus_dc     = cdef.dc;
    assign bus_wr     = cdef.wr;

endmodule

// File: rtl/lbus_seq_chk.sv
module lbus_seq_chk #(
    parameter int ADDR_W = 30,
    parameter int DATA_W = 32,
    localparam int BE_W  = DATA_W / 8
) (
    input logic              clk2,
    input logic              rst,
    input logic              req_valid,
    input logic              req_accept,
    input logic              req_done,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be_n,
    input logic              bus_ads_n,
    input logic              bus_mio,
    input logic              bus_dc,
    input logic              bus_wr,
    input logic              bus_rdy_n,
    input logic [DATA_W-1:0] bus_d_out,
    input logic              bus_d_oe
);

    a_r2_ads_two_ticks: assert property (@(posedge clk2) disable iff (rst)
        $fell(bus_ads_n) |=> !bus_ads_n)
        else $error("R2: strobe low for a single tick");

    a_r2_ads_not_three: assert property (@(posedge clk2) disable iff (rst)
        (!bus_ads_n && $past(!bus_ads_n)) |=> bus_ads_n)
        else $error("R2: strobe low longer than two ticks");

    a_r3_addr_held: assert property (@(posedge clk2) disable iff (rst)
        !$stable(bus_addr) |-> $fell(bus_ads_n))
        else $error("R3: address changed outside a new T1");

    a_r3_def_held: assert property (@(posedge clk2) disable iff (rst)
        !$stable({bus_be_n, bus_mio, bus_dc, bus_wr}) |-> $fell(bus_ads_n))
        else $error("R3: cycle definition changed outside a new T1");

    a_r4_done_needs_ready: assert property (@(posedge clk2) disable iff (rst)
        req_done |-> $past(!bus_rdy_n))
        else $error("R4: cycle ended without ready low");

    a_r5_min_length: assert property (@(posedge clk2) disable iff (rst)
        req_done |-> ($past(bus_ads_n) && $past(bus_ads_n, 2)))
        else $error("R5: cycle shorter than T1 plus one T2");

    a_r6_start_needs_accept: assert property (@(posedge clk2) disable iff (rst)
        $fell(bus_ads_n) |-> $past(req_accept))
        else $error("R6: T1 began without an accepted request");

    a_r7_accept_starts_t1: assert property (@(posedge clk2) disable iff (rst)
        req_accept |=> !bus_ads_n)
        else $error("R7: accepted request did not start T1");

    a_r8_accept_window: assert property (@(posedge clk2) disable iff (rst)
        req_accept |-> (bus_ads_n && req_valid))
        else $error("R8: accept during T1 or without a request");

    a_r9_oe_write_only: assert property (@(posedge clk2) disable iff (rst)
        bus_d_oe |-> bus_wr)
        else $error("R9: data bus driven in a read cycle");

    a_r9_oe_start: assert property (@(posedge clk2) disable iff (rst)
        $rose(bus_d_oe) |-> (!bus_ads_n && $past(!bus_ads_n)))
        else $error("R9: drive did not begin on the second T1 tick");

    a_r9_oe_end: assert property (@(posedge clk2) disable iff (rst)
        $fell(bus_d_oe) |-> req_done)
        else $error("R9: drive released before the cycle ended");

    a_r9_dout_stable: assert property (@(posedge clk2) disable iff (rst)
        (bus_d_oe && $past(bus_d_oe)) |-> $stable(bus_d_out))
        else $error("R9: write data moved while driven");

    a_r10_done_pulse: assert property (@(posedge clk2) disable iff (rst)
        req_done |=> !req_done)
        else $error("R10: done wider than one tick");

    a_r10_rd_on_done: assert property (@(posedge clk2) disable iff (rst)
        !$stable(rd_data) |-> req_done)
        else $error("R10: read data changed without completion");

endmodule

bind lbus_seq lbus_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk2       (clk2),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_accept (req_accept),
    .req_done   (req_done),
    .rd_data    (rd_data),
    .bus_addr   (bus_addr),
    .bus_be_n   (bus_be_n),
    .bus_ads_n  (bus_ads_n),
    .bus_mio    (bus_mio),
    .bus_dc     (bus_dc),
    .bus_wr     (bus_wr),
    .bus_rdy_n  (bus_rdy_n),
    .bus_d_out  (bus_d_out),
    .bus_d_oe   (bus_d_oe)
);

// File: tb/lbus_seq_test.sv
module lbus_seq_test;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 30;
    localparam int DW = 32;
    localparam int BW = DW / 8;

    logic          clk2 = 1'b0;
    logic          rst;
    logic          req_valid, req_write, req_mem, req_data;
    logic [AW-1:0] req_addr;
    logic [BW-1:0] req_be;
    logic [DW-1:0] req_wdata;
    logic          req_accept, req_done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] bus_addr;
    logic [BW-1:0] bus_be_n;
    logic          bus_ads_n, bus_mio, bus_dc, bus_wr;
    logic          bus_rdy_n;
    logic [DW-1:0] bus_d_in, bus_d_out;
    logic          bus_d_oe;

    always #2.5 clk2 = ~clk2;   // 200 MHz

    lbus_seq #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk2(clk2), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_mem(req_mem),
        .req_data(req_data), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_accept(req_accept), .req_done(req_done),
        .rd_data(rd_data), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
        .bus_ads_n(bus_ads_n), .bus_mio(bus_mio), .bus_dc(bus_dc),
        .bus_wr(bus_wr), .bus_rdy_n(bus_rdy_n), .bus_d_in(bus_d_in),
        .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe)
    );

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          finished = 0;

    // request in flight (cur) and the one being queued (nxt)
    logic          cur_w, cur_m, cur_d, nxt_w, nxt_m, nxt_d;
    logic [AW-1:0] cur_a, nxt_a;
    logic [BW-1:0] cur_b, nxt_b;
    logic [DW-1:0] cur_wd, nxt_wd;
    logic [DW-1:0] last_rd = '0;

    function automatic logic [BW-1:0] exp_be_n(input logic [BW-1:0] be);
        return ~be;
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic was_write,
                                             input logic [DW-1:0] old_rd,
                                             input logic [DW-1:0] bus_val);
        return was_write ? old_rd : bus_val;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic draw(input int wsel);
        nxt_w  = (wsel < 0) ? 1'($urandom % 2) : 1'(wsel);
        nxt_m  = 1'($urandom % 2);
        nxt_d  = 1'($urandom % 2);
        nxt_a  = AW'($urandom);
        nxt_b  = BW'($urandom);
        nxt_wd = DW'($urandom);
        req_valid = 1'b1;
        req_write = nxt_w; req_mem = nxt_m; req_data = nxt_d;
        req_addr  = nxt_a; req_be  = nxt_b; req_wdata = nxt_wd;
    endtask

    task automatic scramble();
        req_valid = 1'b0;
        req_write = 1'($urandom % 2); req_mem = 1'($urandom % 2);
        req_data  = 1'($urandom % 2); req_addr = AW'($urandom);
        req_be    = BW'($urandom);    req_wdata = DW'($urandom);
    endtask

    task automatic promote();
        cur_w = nxt_w; cur_m = nxt_m; cur_d = nxt_d;
        cur_a = nxt_a; cur_b = nxt_b; cur_wd = nxt_wd;
    endtask

    task automatic check_fields(input string tag);
        chk({tag, " addr"}, 64'(bus_addr), 64'(cur_a));
        chk({tag, " be_n"}, 64'(bus_be_n), 64'(exp_be_n(cur_b)));
        chk({tag, " def"},  64'({bus_wr, bus_mio, bus_dc}), 64'({cur_w, cur_m, cur_d}));
    endtask

    // Idle for a while, raise a request, return at the first T1 tick.
    task automatic start_from_idle(input int idle_ticks, input int wsel);
        bit got = 0;
        scramble();
        for (int i = 0; i < idle_ticks; i++) begin
            @(negedge clk2);
            #1;
            chk("R6 idle strobe", 64'(bus_ads_n), 64'd1);
            chk("R8 idle accept", 64'(req_accept), 64'd0);
            chk("R9 idle drive",  64'(bus_d_oe), 64'd0);
        end
        @(negedge clk2);
        draw(wsel);
        for (int i = 0; i < 3 && !got; i++) begin
            #1;
            if (req_accept) got = 1;
            else @(negedge clk2);
        end
        chk("R6 accept in Ti", 64'(got), 64'd1);
        @(posedge clk2);
        @(negedge clk2);
        promote();
    endtask

    // Entered at the first T1 tick; leaves at the tick carrying req_done.
    task automatic run_cycle(input int waits, input bit chain, input int next_wsel,
                             input logic [DW-1:0] rdata);
        // T1, phase 1
        bus_rdy_n = 1'($urandom % 2);   // R4: ignored here
        bus_d_in  = DW'($urandom);
        #1;
        chk("R2 T1a strobe", 64'(bus_ads_n), 64'd0);
        check_fields("R3 T1a");
        chk("R9 T1a drive", 64'(bus_d_oe), 64'd0);
        if (chain) draw(next_wsel); else scramble();
        // T1, phase 2
        @(negedge clk2);
        bus_rdy_n = 1'($urandom % 2);
        bus_d_in  = DW'($urandom);
        #1;
        chk("R2 T1b strobe", 64'(bus_ads_n), 64'd0);
        chk("R9 T1b drive", 64'(bus_d_oe), 64'(cur_w));
        if (cur_w) chk("R9 T1b wdata", 64'(bus_d_out), 64'(cur_wd));
        chk("R10 T1b done", 64'(req_done), 64'd0);
        chk("R8 T1b accept", 64'(req_accept), 64'd0);
        for (int k = 0; k <= waits; k++) begin
            @(negedge clk2);               // T2, phase 1
            bus_rdy_n = 1'($urandom % 2);  // R4: not sampled on this tick
            bus_d_in  = DW'($urandom);
            #1;
            chk("R2 T2 strobe", 64'(bus_ads_n), 64'd1);
            chk("R5 T2a done", 64'(req_done), 64'd0);
            chk("R8 T2a accept", 64'(req_accept), 64'd0);
            check_fields("R3 T2");
            chk("R9 T2 drive", 64'(bus_d_oe), 64'(cur_w));
            if (cur_w) chk("R9 T2 wdata", 64'(bus_d_out), 64'(cur_wd));
            @(negedge clk2);               // T2, phase 2
            if (k == waits) begin
                bus_rdy_n = 1'b0;
                bus_d_in  = rdata;
                #1;
                chk("R7 R8 accept at end", 64'(req_accept), 64'(chain));
            end else begin
                bus_rdy_n = 1'b1;
                bus_d_in  = DW'($urandom);
                #1;
                chk("R5 wait accept", 64'(req_accept), 64'd0);
            end
            chk("R5 T2b done", 64'(req_done), 64'd0);
            chk("R9 T2b drive", 64'(bus_d_oe), 64'(cur_w));
        end
        @(negedge clk2);                   // tick after the ending edge
        bus_rdy_n = 1'($urandom % 2);
        bus_d_in  = DW'($urandom);
        #1;
        chk("R10 done pulse", 64'(req_done), 64'd1);
        last_rd = exp_rd(cur_w, last_rd, rdata);
        chk("R10 rd_data", 64'(rd_data), 64'(last_rd));
        chk("R9 released", 64'(bus_d_oe), 64'd0);
        chk("R7 next T1", 64'(bus_ads_n), 64'(!chain));
        if (chain) promote();
        else       bus_rdy_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk2);
        if (!finished) begin
            n_bad++;
            $display("FAIL R5 watchdog actual=hung expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit chained = 0;
        void'($urandom(32'd20517));
        rst = 1'b1;
        bus_rdy_n = 1'b1;
        bus_d_in = '0;
        scramble();
        repeat (4) @(negedge clk2);
        #1;
        chk("R1 reset strobe", 64'(bus_ads_n), 64'd1);
        chk("R1 reset be_n", 64'(bus_be_n), 64'({BW{1'b1}}));
        rst = 1'b0;
        @(negedge clk2);
        #1;
        chk("R1 strobe", 64'(bus_ads_n), 64'd1);
        chk("R1 drive", 64'(bus_d_oe), 64'd0);
        chk("R1 done", 64'(req_done), 64'd0);
        chk("R1 accept", 64'(req_accept), 64'd0);
        chk("R1 rd_data", 64'(rd_data), 64'd0);

        // directed: read with no wait, write with three, write then read back to back
        start_from_idle(2, 0);
        run_cycle(0, 1'b0, 0, 32'hA5A5_0F0F);
        start_from_idle(1, 1);
        run_cycle(3, 1'b0, 0, 32'h1234_5678);
        start_from_idle(0, 1);
        run_cycle(0, 1'b1, 0, 32'hDEAD_BEEF);    // write, chained to a read
        run_cycle(1, 1'b1, 1, 32'hCAFE_F00D);    // read, chained to a write
        run_cycle(12, 1'b0, 0, 32'h0BAD_C0DE);   // long wait

        // random mix
        for (int i = 0; i < 60; i++) begin
            bit ch = (i == 59) ? 1'b0 : 1'($urandom % 2);
            if (!chained) start_from_idle(int'($urandom % 4), -1);
            run_cycle(int'($urandom % 5), ch, -1, DW'($urandom));
            chained = ch;
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule